// File: doc/BRIEF.md
# Multi-register contiguous vector load sequencer

This block carries out a predicated, contiguous load of 64-bit elements into either two or four consecutive destination vector registers. A start pulse delivers the operands: a base register identifier together with the general-register value and the stack-pointer value, a 64-bit element index, a register-count select, a destination register field and a per-byte predicate mask. The mask is already expanded and covers the largest register group. The block forms the first address from the base plus the index scaled by eight. It then steps through every element slot in order. Each active slot is fetched through a single-outstanding request/response memory port, and each inactive slot is filled with zero.

When every slot has been gathered, the assembled vectors are written out, one register per cycle, on a register write port, and a done pulse follows the last write. A stack-pointer base whose low four bits are not zero is refused: the block raises an alignment error pulse and does nothing else. The index operand is only read. No updated index ever leaves the block.

Top module: `vec_multi_load_seq`

## Requirements
- R1: The first element slot uses address base + (index << 3), computed modulo 2^64. The base is `sp_base` when `base_id` equals 31 and `gp_base` otherwise.
- R2: The address increases by 8 after every element slot, whether the slot is active or not.
- R3: Slots are visited register by register and, inside a register, from element 0 upward. Slot k (k = r*ELEMS + e, ELEMS = VLEN/64) is active when `pmask` bit 8*k is set. The other seven bits of each mask byte, and the mask bytes beyond the selected register count, have no effect.
- R4: An inactive slot issues no memory request, and its 64-bit element (bits 64*e+63..64*e of its register's write data) is written as zero.
- R5: `four_regs`=0 selects two registers starting at `dst_field`*2. `four_regs`=1 selects four registers starting at `dst_field[2:0]`*4. The registers that follow are numbered consecutively.
- R6: A stack-pointer base (`base_id`=31) with nonzero low four bits makes `align_err` high for exactly one cycle, the cycle after the start pulse, with no request, no write and no done. A misaligned general-register base is accepted.
- R7: Every memory request has `req_nt` at 1.
- R8: A request holds `req_valid` and `req_addr` until `req_ready`. At most one request is outstanding, and its data is taken on the cycle `rsp_valid` is high.
- R9: Register writes happen only after all slots are gathered. They go one per cycle in ascending register order, and `done` is high for one cycle, the cycle after the last write.
- R10: A start pulse is ignored while an operation is in progress.
- R11: After reset, `req_valid`, `wr_en`, `done` and `align_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (idle only) |
| base_id | input | 5 | Base register identifier; 31 selects the stack pointer |
| gp_base | input | 64 | General-register base value |
| sp_base | input | 64 | Stack-pointer base value |
| index_in | input | 64 | Element index, scaled by 8 |
| four_regs | input | 1 | 0: two registers, 1: four registers |
| dst_field | input | 4 | Destination register field |
| pmask | input | 4*VLEN/8 | Per-byte predicate mask |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 64 | Request byte address |
| req_nt | output | 1 | Non-temporal hint, always 1 |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Read data |
| wr_en | output | 1 | Register write strobe |
| wr_reg | output | 5 | Register number written |
| wr_data | output | VLEN | Register contents |
| done | output | 1 | Operation finished pulse |
| align_err | output | 1 | Stack-pointer misalignment pulse |

## Verification
The bound assertions check the handshake rules on every cycle: a request held stable while stalled, no second request while one is in flight, and no request during the write phase. They also check that writes climb by one register, that done follows a write, and that an alignment error occurs only right after a start and in a quiet port state. Only the bench scenarios can show the address arithmetic, including wraparound, and the per-slot mask decoding. The same goes for zero fill in the correct element positions, the destination numbering for both register counts, and the fact that a second start during a run leaves the results unchanged.

// File: rtl/vec_multi_load_seq.sv
module vec_multi_load_seq #(
  parameter int VLEN = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [4:0]          base_id,
  input  logic [63:0]         gp_base,
  input  logic [63:0]         sp_base,
  input  logic [63:0]         index_in,
  input  logic                four_regs,
  input  logic [3:0]          dst_field,
  input  logic [4*VLEN/8-1:0] pmask,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [63:0]         req_addr,
  output logic                req_nt,
  input  logic                rsp_valid,
  input  logic [63:0]         rsp_data,
  output logic                wr_en,
  output logic [4:0]          wr_reg,
  output logic [VLEN-1:0]     wr_data,
  output logic                done,
  output logic                align_err
);
  localparam int ELEMS = VLEN / 64;
  localparam int SLOTS = 4 * ELEMS;
  localparam int SW    = $clog2(SLOTS);
  localparam int EB    = $clog2(ELEMS);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_WRITE} st_t;

  st_t                          st_q;
  logic [SW-1:0]                slot_q;
  logic [1:0]                   wcnt_q;
  logic                         four_q;
  logic [4:0]                   first_q;
  logic [63:0]                  addr_q;
  logic [SLOTS-1:0]             act_q;
  logic [3:0][ELEMS-1:0][63:0]  data_q;
  logic                         done_q, align_q;

  logic [SLOTS-1:0]   act_in;
  logic [SLOTS*7-1:0] unused_mask_hi;
  for (genvar k = 0; k < SLOTS; k++) begin : g_act
    assign act_in[k]                 = pmask[8*k];
    assign unused_mask_hi[7*k +: 7]  = pmask[8*k+1 +: 7];
  end
  logic unused_sink;
  assign unused_sink = ^unused_mask_hi;

  logic        sp_sel, misalign, active, last_slot, last_wr, slot_done;
  logic [63:0] base_w;

  assign sp_sel    = (base_id == 5'd31);
  assign base_w    = sp_sel ? sp_base : gp_base;
  assign misalign  = sp_sel && (base_w[3:0] != 4'd0);
  assign active    = act_q[slot_q];
  assign last_slot = slot_q == (four_q ? SW'(SLOTS - 1) : SW'(SLOTS/2 - 1));
  assign last_wr   = wcnt_q == (four_q ? 2'd3 : 2'd1);
  assign slot_done = (st_q == S_RUN && !active) || (st_q == S_WAIT && rsp_valid);

  assign req_valid = (st_q == S_RUN) && active;
  assign req_addr  = addr_q;
  assign req_nt    = 1'b1;
  assign wr_en     = (st_q == S_WRITE);
  assign wr_reg    = first_q + {3'b000, wcnt_q};
  assign wr_data   = data_q[wcnt_q];
  assign done      = done_q;
  assign align_err = align_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      slot_q  <= '0;
      wcnt_q  <= '0;
      four_q  <= 1'b0;
      first_q <= '0;
      addr_q  <= '0;
      act_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      align_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          if (misalign) begin
            align_q <= 1'b1;
          end else begin
            st_q    <= S_RUN;
            slot_q  <= '0;
            wcnt_q  <= '0;
            four_q  <= four_regs;
            first_q <= four_regs ? {dst_field[2:0], 2'b00} : {dst_field, 1'b0};
            addr_q  <= base_w + (index_in << 3);
            act_q   <= act_in;
          end
        end
        S_RUN:   if (active && req_ready) st_q <= S_WAIT;
        S_WRITE: begin
          wcnt_q <= wcnt_q + 2'd1;
          if (last_wr) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
      if (slot_done) begin
        data_q[slot_q[SW-1:EB]][slot_q[EB-1:0]] <= (st_q == S_WAIT) ? rsp_data : 64'd0;
        addr_q <= addr_q + 64'd8;
        slot_q <= slot_q + 1'b1;
        st_q   <= last_slot ? S_WRITE : S_RUN;
      end
    end
  end
endmodule

// File: rtl/vec_multi_load_seq_chk.sv
module vec_multi_load_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        wr_en,
  input logic [4:0]  wr_reg,
  input logic        done,
  input logic        align_err
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R8
  AST_WRITE_AFTER_GATHER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_valid); // R9
  AST_WRITE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_reg == $past(wr_reg) + 5'd1); // R9
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && !wr_en); // R9
  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> $past(start) && !req_valid && !wr_en && !done); // R6
endmodule

bind vec_multi_load_seq vec_multi_load_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .wr_en(wr_en),
  .wr_reg(wr_reg), .done(done), .align_err(align_err)
);

// File: tb/vec_multi_load_seq_tb.sv
`timescale 1ns/1ps
module vec_multi_load_seq_tb;
  localparam int VLEN = 256;
  localparam int E    = VLEN / 64;
  localparam int MW   = 4 * VLEN / 8;
  localparam int N    = 6;

  localparam logic        T_FOUR  [N] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [3:0]  T_DST   [N] = '{4'd3, 4'd1, 4'd7, 4'd15, 4'd2, 4'd5};
  localparam logic [4:0]  T_ID    [N] = '{5'd5, 5'd12, 5'd31, 5'd0, 5'd31, 5'd7};
  localparam logic [63:0] T_GP    [N] = '{64'h1000, 64'h2000_0000_0000_0008, 64'h0,
                                          64'h40_0000, 64'h0, 64'h3000};
  localparam logic [63:0] T_SP    [N] = '{64'h0, 64'h0, 64'h7ff0, 64'hdead_0003,
                                          64'hFFFF_FFFF_FFFF_FFF0, 64'h0};
  localparam logic [63:0] T_IDX   [N] = '{64'd2, 64'h10, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF,
                                          64'h2000_0000_0000_0003, 64'd0};
  localparam logic [MW-1:0] T_MASK[N] = '{
    128'h0101_0101_0101_0101_0101_0101_0101_0101,
    128'h0001_0001_0001_0001_0001_0001_0001_0001,
    128'h0,
    128'hFFFF_FFFF_FFFF_FFFF_0100_0000_0000_0000,
    128'h0101_FE01_0000_0101_01FF_0001_FE00_0101,
    128'hFEFE_FEFE_FEFE_FEFE_FEFE_FEFE_FEFE_FEFE};
  localparam logic        T_STALL [N] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] base_id = '0;
  logic [63:0] gp_base = '0, sp_base = '0, index_in = '0;
  logic four_regs = 1'b0;
  logic [3:0] dst_field = '0;
  logic [MW-1:0] pmask = '0;
  logic req_valid, req_nt, wr_en, done, align_err;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [63:0] req_addr, rsp_data = '0;
  logic [4:0] wr_reg;
  logic [VLEN-1:0] wr_data;

  vec_multi_load_seq #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_id(base_id), .gp_base(gp_base),
    .sp_base(sp_base), .index_in(index_in), .four_regs(four_regs), .dst_field(dst_field),
    .pmask(pmask), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_nt(req_nt), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wr_en(wr_en),
    .wr_reg(wr_reg), .wr_data(wr_data), .done(done), .align_err(align_err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic stall_mode = 1'b0, acc_pend = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [63:0] req_log [64];
  logic [4:0] wreg_log [8];
  logic [VLEN-1:0] wdat_log [8];
  int req_n = 0, nt_bad = 0, wr_n = 0, done_n = 0, align_n = 0, last_wr_cyc = 0, done_cyc = 0;

  function automatic logic [63:0] fmem(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_C3C3, ~a[63:32]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin : mem_model
    logic nr;
    nr = stall_mode ? ~req_ready : 1'b1;
    req_ready <= nr;
    rsp_valid <= acc_pend;
    rsp_data  <= fmem(acc_addr);
    acc_pend  <= req_valid && nr;
    acc_addr  <= req_addr;
    if (req_valid && nr) begin
      if (req_n < 64) req_log[req_n] = req_addr;
      req_n = req_n + 1;
      if (req_nt !== 1'b1) nt_bad = nt_bad + 1;
    end
    if (wr_en) begin
      if (wr_n < 8) begin wreg_log[wr_n] = wr_reg; wdat_log[wr_n] = wr_data; end
      wr_n = wr_n + 1;
      last_wr_cyc = cyc;
    end
    if (done) begin done_n = done_n + 1; done_cyc = cyc; end
    if (align_err) align_n = align_n + 1;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string rq, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic run_case(input logic f4, input logic [3:0] dst, input logic [4:0] id,
                          input logic [63:0] gp, input logic [63:0] sp, input logic [63:0] idx,
                          input logic [MW-1:0] m, input logic stall, input logic restart);
    logic [63:0] a;
    logic [3:0][E-1:0][63:0] ev;
    logic [4:0] first;
    int ereq, nreg, ns;
    logic exp_al;
    tick();
    req_n = 0; nt_bad = 0; wr_n = 0; done_n = 0; align_n = 0;
    stall_mode = stall;
    base_id = id; gp_base = gp; sp_base = sp; index_in = idx;
    four_regs = f4; dst_field = dst; pmask = m; start = 1'b1;
    tick();
    start = 1'b0;
    if (restart) begin
      tick(); tick();
      index_in = idx + 64'd100; four_regs = ~f4; dst_field = dst + 4'd1; start = 1'b1;
      tick();
      start = 1'b0;
    end
    for (int w = 0; w < 400 && done_n == 0 && align_n == 0; w++) tick();
    for (int w = 0; w < 4; w++) tick();

    exp_al = (id == 5'd31) && (sp[3:0] != 4'd0);
    if (exp_al) begin
      chk(align_n == 1, "R6 align pulse", align_n, 1);
      chk(req_n == 0 && wr_n == 0 && done_n == 0, "R6 quiet", req_n + wr_n + done_n, 0);
    end else begin
      a = ((id == 5'd31) ? sp : gp) + (idx << 3);
      nreg = f4 ? 4 : 2;
      ns = nreg * E;
      first = f4 ? {dst[2:0], 2'b00} : {dst, 1'b0};
      ev = '0;
      ereq = 0;
      for (int s = 0; s < ns; s++) begin
        if (m[8*s]) begin
          if (ereq < req_n)
            chk(req_log[ereq] == a, (s == 0) ? "R1 first address" : "R2/R3 slot address",
                req_log[ereq], a);
          ev[s / E][s % E] = fmem(a);
          ereq++;
        end
        a = a + 64'd8;
      end
      chk(req_n == ereq, "R4 request count", req_n, ereq);
      chk(nt_bad == 0, "R7 non-temporal flag", nt_bad, 0);
      chk(wr_n == nreg, "R5 write count", wr_n, nreg);
      for (int r = 0; r < nreg && r < wr_n; r++) begin
        chk(wreg_log[r] == first + 5'(r), "R5 destination number", wreg_log[r], first + 5'(r));
        chk(wdat_log[r] == ev[r], "R3/R4 register data", wdat_log[r], ev[r]);
      end
      chk(done_n == 1, "R9 done count", done_n, 1);
      chk(done_cyc == last_wr_cyc + 1, "R9 done timing", done_cyc, last_wr_cyc + 1);
      chk(align_n == 0, "R6 no align error", align_n, 0);
    end
  endtask

  bit finished = 0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk(req_valid == 0 && wr_en == 0 && done == 0 && align_err == 0, "R11 reset state",
        {req_valid, wr_en, done, align_err}, 0);

    for (int i = 0; i < N; i++)
      run_case(T_FOUR[i], T_DST[i], T_ID[i], T_GP[i], T_SP[i], T_IDX[i], T_MASK[i], T_STALL[i], 1'b0);

    // R6: misaligned stack-pointer base is refused
    run_case(1'b1, 4'd2, 5'd31, 64'h0, 64'h7ff8, 64'd1, {MW{1'b1}}, 1'b0, 1'b0);
    // R6: misaligned general-register base is accepted
    run_case(1'b0, 4'd4, 5'd30, 64'h1234_5674, 64'h7ff8, 64'd3, {MW{1'b1}}, 1'b1, 1'b0);
    // R10: a second start during a run is ignored
    run_case(1'b0, 4'd6, 5'd9, 64'h8000, 64'h0, 64'd7, {MW{1'b1}}, 1'b1, 1'b1);
    // R8: stalled ready with sparse mask, four registers
    run_case(1'b1, 4'd0, 5'd31, 64'h0, 64'h100, 64'd0, 128'h0100_0001_0000_0100_0001_0000_0001_0001,
             1'b1, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule